// File: doc/BRIEF.md
# Read Burst Sequencer for a Chip-Select Paced DDR Pseudo-Static RAM

This block turns a host read request (start address, word count, incrementing or wrapping order) into one or more memory read bursts on a chip-select driven DDR pseudo-static RAM. It opens a burst by pulling chip-select low and pulsing a start strobe with the burst address and order. It then passes each word from the serial data recovery stage to the host, tagging the final word of the request. The recovery stage is modelled as a valid/data stream with a reset input.

Closing a burst is the delicate part. The recovery stage can hold back a word for one cycle while it waits for one more bit, so one cycle with valid low does not mean the burst has ended. Once chip-select rises, the sequencer drains the words still in flight. It sends the recovery reset only after two valid-low cycles in a row. Chip-select low time is bounded by a parameter. When that limit ends a burst before the request is complete, the remaining words are fetched by a new burst. Its address wraps inside the aligned 16-word window for wrapping requests and advances linearly for incrementing ones.

States: `ST_IDLE` (ready for a request), `ST_ISSUE` (chip-select low, start strobe), `ST_STREAM` (chip-select low, accepting words, timer running), `ST_DRAIN` (chip-select high, accepting in-flight words), `ST_CONFIRM` (one valid-low cycle seen, waiting for a second), `ST_DONE` (burst closed). Transitions: IDLE→ISSUE on a request; ISSUE→STREAM always; STREAM→DRAIN when the last word is taken or the low-time limit is reached; DRAIN→CONFIRM on valid low; CONFIRM→DRAIN on valid high; CONFIRM→DONE on a second valid low, together with the recovery reset pulse; DONE→IDLE when all words are delivered, otherwise DONE→ISSUE for the next burst.

Top module: `burst_read_seq`

## Requirements
- R1: After reset, `req_ready` is 1 and `mem_cs_n` is 1. `req_ready` is high only in the idle state. It is high only when `mem_cs_n` was high in the previous cycle, and it drops in the cycle after a request is taken.
- R2: A wrapping request (`req_wrap`=1) delivers exactly 16 words whatever `req_len` holds. Word k comes from address {start[AW-1:4], (start+k) mod 16}, so every word lies in the aligned 16-word window.
- R3: An incrementing request delivers `req_len` words from addresses start, start+1, … modulo 2^AW. A `req_len` of 0 is treated as 1.
- R4: A single cycle with `rec_valid` low after chip-select rises does not close the burst. If `rec_valid` returns high in the next cycle, that word and the words after it are still delivered.
- R5: `rec_rst` pulses for one cycle only when `rec_valid` was low in the previous cycle and is low in the current one, after the drain phase. There is exactly one pulse per memory burst.
- R6: `mem_cs_n` stays low for at most CS_MAX_CYC consecutive cycles. The count restarts at every burst start.
- R7: For an incrementing request that is split, each new burst starts at the original address plus the number of words already delivered.
- R8: For a wrapping request that is split, each new burst starts at {start[AW-1:4], (start+delivered) mod 16}. It is never the window address plus 16.
- R9: `rd_valid` pulses exactly as many times as the request length. `rd_last` is high only on the final word. Recovered words beyond that count are discarded.
- R10: `mem_start` is high for one cycle, with `mem_cs_n` low, at the start of every burst. `mem_wrap` in that cycle carries the request's order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Sequencer can take a request |
| req_addr | input | AW | Start word address |
| req_len | input | LW | Word count for incrementing requests |
| req_wrap | input | 1 | 1 = wrapping 16-word request, 0 = incrementing |
| rd_valid | output | 1 | Delivered word strobe |
| rd_data | output | DW | Delivered word |
| rd_last | output | 1 | Final word of the request |
| mem_cs_n | output | 1 | Memory chip-select, active low |
| mem_start | output | 1 | Burst start strobe |
| mem_addr | output | AW | Burst start address, valid with `mem_start` |
| mem_wrap | output | 1 | Burst order, valid with `mem_start` |
| rec_valid | input | 1 | Recovered word valid |
| rec_data | input | DW | Recovered word |
| rec_rst | output | 1 | Reset pulse to the recovery stage |

## Verification
The assertions check these properties on every cycle: the recovery reset follows two valid-low cycles after the drain, a valid word in the confirm state sends the block back to draining, the chip-select low count stays under its limit, no word is taken once the count is met, no burst is reissued for a complete request, and readiness only follows a high chip-select. Only the bench's scenarios can show the rest. These are the address and order of every delivered word, the wrap-aware and linear resume addresses after a split, the exact word total with its last flag, and the recovery of words that arrive after a lone gap. The bench shows them against a memory model that streams with latency and inserts random single-cycle gaps.

// File: rtl/brs_pkg.sv
package brs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_STREAM,
        ST_DRAIN,
        ST_CONFIRM,
        ST_DONE
    } brs_state_e;

endpackage

// File: rtl/brs_cs_timer.sv
module brs_cs_timer #(
    parameter int CS_MAX_CYC = 64,
    localparam int CW = $clog2(CS_MAX_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic limit_hit
);
    localparam logic [CW:0] LIMIT = (CW + 1)'(CS_MAX_CYC);

    logic [CW-1:0] low_cnt;
    logic [CW:0]   cnt_nxt;

    assign cnt_nxt   = {1'b0, low_cnt} + (CW + 1)'(1);
    assign limit_hit = run && (cnt_nxt >= LIMIT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt <= '0;
        end else if (clear) begin
            low_cnt <= CW'(1);
        end else if (run && !limit_hit) begin
            low_cnt <= cnt_nxt[CW-1:0];
        end
    end

    AST_CS_WITHIN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> ({1'b0, low_cnt} < LIMIT)); // R6

endmodule

// File: rtl/brs_addr_track.sv
module brs_addr_track #(
    parameter int AW = 16,
    parameter int LW = 8,
    parameter int WRAP_WORDS = 16,
    localparam int WB = $clog2(WRAP_WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] ld_addr,
    input  logic [LW-1:0] ld_len,
    input  logic          ld_wrap,
    input  logic          take,
    input  logic          issue,
    output logic [AW-1:0] cont_addr,
    output logic          wrap_mode,
    output logic          last_word,
    output logic          xfer_complete
);
    logic [AW-1:0] start_q;
    logic [LW-1:0] len_q;
    logic [LW-1:0] done_q;
    logic [AW-1:0] lin_sum;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q   <= '0;
            len_q     <= LW'(1);
            done_q    <= '0;
            wrap_mode <= 1'b0;
        end else if (load) begin
            start_q   <= ld_addr;
            wrap_mode <= ld_wrap;
            done_q    <= '0;
            if (ld_wrap) begin
                len_q <= LW'(WRAP_WORDS);
            end else if (ld_len == '0) begin
                len_q <= LW'(1);
            end else begin
                len_q <= ld_len;
            end
        end else if (take) begin
            done_q <= done_q + LW'(1);
        end
    end

    assign lin_sum       = start_q + AW'(done_q);
    assign last_word     = (done_q + LW'(1)) == len_q;
    assign xfer_complete = (done_q == len_q);

    generate
        if (AW > WB) begin : g_wrap_join
            assign cont_addr = wrap_mode ? {start_q[AW-1:WB], lin_sum[WB-1:0]} : lin_sum;
        end else begin : g_wrap_full
            assign cont_addr = lin_sum;
        end
    endgenerate

    AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_complete |-> !take); // R9

    AST_ISSUE_NEEDS_WORK: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> !xfer_complete); // R7

endmodule

// File: rtl/brs_fsm.sv
module brs_fsm
    import brs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic rec_valid,
    input  logic last_word,
    input  logic xfer_complete,
    input  logic limit_hit,
    output logic req_ready,
    output logic host_load,
    output logic issue,
    output logic stream,
    output logic take_word,
    output logic cs_n,
    output logic rec_rst
);
    brs_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (req_valid) state_d = ST_ISSUE;
            ST_ISSUE:   state_d = ST_STREAM;
            ST_STREAM:  if (limit_hit || (take_word && last_word)) state_d = ST_DRAIN;
            ST_DRAIN:   if (!rec_valid) state_d = ST_CONFIRM;
            ST_CONFIRM: state_d = rec_valid ? ST_DRAIN : ST_DONE;
            ST_DONE:    state_d = xfer_complete ? ST_IDLE : ST_ISSUE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        req_ready = (state_q == ST_IDLE);
        host_load = (state_q == ST_IDLE) && req_valid;
        issue     = (state_q == ST_ISSUE);
        stream    = (state_q == ST_STREAM);
        cs_n      = !((state_q == ST_ISSUE) || (state_q == ST_STREAM));
        take_word = rec_valid && !xfer_complete &&
                    ((state_q == ST_STREAM) || (state_q == ST_DRAIN) || (state_q == ST_CONFIRM));
        rec_rst   = (state_q == ST_CONFIRM) && !rec_valid;
    end

    AST_RST_TWO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        rec_rst |-> (!rec_valid && !$past(rec_valid) && ($past(state_q) == ST_DRAIN))); // R5

    AST_GAP_KEEPS_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_CONFIRM) && rec_valid) |=> ((state_q == ST_DRAIN) && !rec_rst)); // R4

    AST_READY_AFTER_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> $past(cs_n)); // R1

    AST_START_WITH_CS: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> (!cs_n && !issue)); // R10

endmodule

// File: rtl/burst_read_seq.sv
module burst_read_seq #(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int LW = 8,
    parameter int WRAP_WORDS = 16,
    parameter int CS_MAX_CYC = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic [LW-1:0] req_len,
    input  logic          req_wrap,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic          rd_last,
    output logic          mem_cs_n,
    output logic          mem_start,
    output logic [AW-1:0] mem_addr,
    output logic          mem_wrap,
    input  logic          rec_valid,
    input  logic [DW-1:0] rec_data,
    output logic          rec_rst
);
    logic host_load, issue, stream, take_word;
    logic last_word, xfer_complete, limit_hit;

    brs_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .rec_valid    (rec_valid),
        .last_word    (last_word),
        .xfer_complete(xfer_complete),
        .limit_hit    (limit_hit),
        .req_ready    (req_ready),
        .host_load    (host_load),
        .issue        (issue),
        .stream       (stream),
        .take_word    (take_word),
        .cs_n         (mem_cs_n),
        .rec_rst      (rec_rst)
    );

    brs_addr_track #(
        .AW(AW), .LW(LW), .WRAP_WORDS(WRAP_WORDS)
    ) u_addr (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (host_load),
        .ld_addr      (req_addr),
        .ld_len       (req_len),
        .ld_wrap      (req_wrap),
        .take         (take_word),
        .issue        (issue),
        .cont_addr    (mem_addr),
        .wrap_mode    (mem_wrap),
        .last_word    (last_word),
        .xfer_complete(xfer_complete)
    );

    brs_cs_timer #(
        .CS_MAX_CYC(CS_MAX_CYC)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (issue),
        .run      (stream),
        .limit_hit(limit_hit)
    );

    assign mem_start = issue;
    assign rd_valid  = take_word;
    assign rd_data   = rec_data;
    assign rd_last   = take_word && last_word;

endmodule

// File: tb/burst_read_seq_tb_top.sv
`timescale 1ns/1ps
module burst_read_seq_tb_top;
    localparam int AW = 16, DW = 16, LW = 8, WW = 16, CSM = 10, LAT = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_wrap = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [LW-1:0] req_len = '0;
    logic req_ready, rd_valid, rd_last, mem_cs_n, mem_start, mem_wrap, rec_rst;
    logic [DW-1:0] rd_data;
    logic [AW-1:0] mem_addr;
    logic rec_valid = 1'b0;
    logic [DW-1:0] rec_data = '0;

    always #4 clk = ~clk;

    burst_read_seq #(.AW(AW), .DW(DW), .LW(LW), .WRAP_WORDS(WW), .CS_MAX_CYC(CSM)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .req_wrap(req_wrap),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_last(rd_last),
        .mem_cs_n(mem_cs_n), .mem_start(mem_start), .mem_addr(mem_addr), .mem_wrap(mem_wrap),
        .rec_valid(rec_valid), .rec_data(rec_data), .rec_rst(rec_rst));

    int checks = 0, failures = 0, cycles = 0;
    int exp_len = 1, delivered = 0, starts = 0, rsts = 0, gap_pct = 25;
    logic [AW-1:0] exp_start = '0;
    bit exp_wrap = 0;

    function automatic logic [AW-1:0] addr_at(logic [AW-1:0] a, int i, bit w);
        logic [AW-1:0] s;
        s = a + AW'(i);
        return w ? {a[AW-1:4], s[3:0]} : s;
    endfunction

    function automatic logic [DW-1:0] word_of(logic [AW-1:0] a);
        return (a * 16'h9E37) ^ 16'h5A5A;
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // memory + recovery model
    logic [DW-1:0] q[$];
    logic [AW-1:0] m_addr = '0;
    bit m_wrap = 0, prev_gap = 0;
    int m_lat = 0, cs_run = 0;
    bit s_valid = 0, s_rst = 0, s_cs_low = 0, s_start = 0, s_mwrap = 0, s_ready = 1, s_cs_n = 1;
    logic [AW-1:0] s_maddr = '0;

    initial begin
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                q.delete();
                rec_valid = 1'b0;
            end else begin
                if (s_valid && q.size() > 0) void'(q.pop_front());
                if (s_rst) q.delete();
                if (s_start) begin
                    m_addr = s_maddr; m_wrap = s_mwrap; m_lat = LAT;
                end else if (s_cs_low) begin
                    if (m_lat > 0) m_lat--;
                    else begin
                        q.push_back(word_of(m_addr));
                        m_addr = m_wrap ? {m_addr[AW-1:4], m_addr[3:0] + 4'd1} : m_addr + 1'b1;
                    end
                end
                begin
                    bit gap;
                    gap = !prev_gap && (q.size() > 0) && ($urandom_range(99) < gap_pct);
                    prev_gap = gap;
                    rec_valid = (q.size() > 0) && !gap;
                    rec_data = (q.size() > 0) ? q[0] : DW'($urandom);
                end
                #1;
                if (rec_rst) begin
                    rsts++;
                    chk(!rec_valid && !s_valid, "R5", "reset without two low cycles", s_valid, 0);
                end
                if (mem_start) begin
                    starts++;
                    chk(!mem_cs_n, "R10", "cs with start", mem_cs_n, 0);
                    chk(mem_wrap == exp_wrap, "R10", "burst order", mem_wrap, exp_wrap);
                    chk(mem_addr == addr_at(exp_start, delivered, exp_wrap), exp_wrap ? "R8" : "R7",
                        "burst address", mem_addr, addr_at(exp_start, delivered, exp_wrap));
                end
                if (!mem_cs_n) cs_run++;
                else begin
                    if (cs_run > 0) chk(cs_run <= CSM, "R6", "cs low run", cs_run, CSM);
                    cs_run = 0;
                end
                if (rd_valid) begin
                    chk(delivered < exp_len, "R9", "extra word", delivered, exp_len);
                    chk(rd_data == word_of(addr_at(exp_start, delivered, exp_wrap)),
                        exp_wrap ? "R2" : "R3", "word data", rd_data,
                        word_of(addr_at(exp_start, delivered, exp_wrap)));
                    chk(rd_last == (delivered == exp_len - 1), "R9", "last flag", rd_last,
                        delivered == exp_len - 1);
                    delivered++;
                end
                if (req_ready && !s_ready) chk(s_cs_n, "R1", "ready after cs high", s_cs_n, 1);
                s_valid = rec_valid; s_rst = rec_rst; s_cs_low = !mem_cs_n; s_cs_n = mem_cs_n;
                s_start = mem_start; s_maddr = mem_addr; s_mwrap = mem_wrap; s_ready = req_ready;
            end
        end
    end

    task automatic do_req(logic [AW-1:0] a, int l, bit w, int gp);
        int n;
        do begin @(negedge clk); #2; end while (!req_ready);
        @(negedge clk);
        n = w ? WW : ((l == 0) ? 1 : l);
        exp_start = a; exp_wrap = w; exp_len = n; delivered = 0; starts = 0; rsts = 0;
        gap_pct = gp;
        req_addr = a; req_len = LW'(l); req_wrap = w; req_valid = 1'b1;
        @(negedge clk); #2;
        req_valid = 1'b0;
        chk(!req_ready, "R1", "ready drops after accept", req_ready, 0);
        do begin @(negedge clk); #2; end while (!req_ready);
        chk(delivered == n, w ? "R2" : "R9", "word total", delivered, n);
        chk(rsts == starts, "R5", "one reset per burst", rsts, starts);
        if (n > CSM) chk(starts > 1, "R6", "long request split", starts, 2);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'hC0FFEE));
        repeat (4) @(negedge clk);
        #2;
        chk(req_ready == 1'b1, "R1", "reset ready", req_ready, 1);
        chk(mem_cs_n == 1'b1, "R1", "reset cs", mem_cs_n, 1);
        chk(rd_valid == 1'b0 && rec_rst == 1'b0, "R1", "reset strobes", rd_valid, 0);
        @(negedge clk); rst_n = 1'b1;
        // directed corners
        do_req(16'h123F, 0, 1, 25);   // R8 wrap from top of window
        do_req(16'h1230, 3, 1, 50);   // R2 req_len ignored, gap-heavy drain (R4)
        do_req(16'h0007, 40, 0, 25);  // R7 split incremental
        do_req(16'hFFFE, 5, 0, 0);    // R3 address rollover, no gaps
        do_req(16'h0100, 0, 0, 25);   // R3 length 0 means 1
        do_req(16'h0AB5, 1, 0, 50);   // R9 single word
        do_req(16'h77F9, 0, 1, 50);   // R4 R8 wrap with gaps
        for (int k = 0; k < 30; k++) begin
            bit w;
            w = $urandom_range(1) == 1;
            do_req(AW'($urandom), int'($urandom_range(60)), w, int'($urandom_range(50)));
        end
        repeat (5) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule